// File: doc/BRIEF.md
# Dual Wiper Register Serial Slave

This block is a slave on a two-wire serial bus (clock line plus open-drain data line) that holds two independent 8-bit wiper position codes. Each code picks one of 256 taps on an external resistor ladder. Code FFh selects the high-end terminal and code 00h selects the low-end terminal. Both lines are sampled by the system clock through a synchronizer. The block recognises START and STOP conditions and matches its 7-bit device address, which is a fixed upper nibble plus three strap inputs. It then carries out register writes and read-back.

A write transfer sends the address with the direction bit low, then a command byte naming the target register or registers, then one data byte. A read transfer sends the address with the direction bit high. The slave then returns wiper 0 followed by wiper 1, and it stops driving after the master declines a byte. The slave never stretches the clock. It signals on the data line only through a pull-down enable.

Top module: `dual_wiper_slave`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, both wiper outputs are 00h and `sda_pull` is 0.
- R2: The device address is the 7 bits {0101b, strap[2:0]}, received MSB first, with the direction bit after it (0 means write, 1 means read). The slave acknowledges a matching address by pulling SDA low during the ninth clock. On a mismatch it leaves SDA released for the rest of the transfer, including every later byte, until the next START.
- R3: Command byte A9h followed by a data byte loads that data into wiper 0 only.
- R4: Command byte AAh loads wiper 1 only. Command byte AFh loads the same data into both wipers.
- R5: A wiper changes only after the ninth (ACK) clock of its data byte has ended, at the falling SCL edge. During the high phase of that ACK clock the old value is still present.
- R6: A command byte other than A9h, AAh or AFh is not acknowledged. The data byte that follows it is not acknowledged either, and neither wiper changes.
- R7: On a read, the slave sends wiper 0 and then wiper 1, MSB first. It changes `sda_pull` only while SCL is low, so every bit is stable through the SCL high phase.
- R8: After the master leaves the acknowledge bit high (NACK) following a read byte, the slave releases SDA until the next START. Further clocks read back FFh.
- R9: A STOP (SDA rising while SCL is high) returns the slave to idle and discards a partly received byte without changing any wiper. A START part-way through a byte restarts address reception.
- R10: Only one data byte is taken per write transfer. A further byte in the same transfer is not acknowledged and changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| strap | input | 3 | Low three bits of the device address |
| wiper0 | output | 8 | Registered position code of wiper 0 |
| wiper1 | output | 8 | Registered position code of wiper 1 |
| sda_pull | output | 1 | Open-drain enable; 1 pulls the data line low |

## Verification
The hardest situation to reach from the ports is the window inside the ACK clock of a data byte. There the byte has been fully received, but the register must still hold its old value until SCL falls. The bench reaches it by driving the ninth clock one phase at a time and sampling the wiper during the high phase and again after the fall. A similar window is a STOP or repeated START cut into a partial byte. The bench makes it by sending a chosen number of bits and then issuing the condition. Random transfers mix good and bad addresses, known and unknown commands and read-backs against a bench model of both wipers.

// File: rtl/dws_pkg.sv
package dws_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;

  localparam logic [BYTE_W-1:0] CMD_LOAD0    = 8'hA9;
  localparam logic [BYTE_W-1:0] CMD_LOAD1    = 8'hAA;
  localparam logic [BYTE_W-1:0] CMD_LOADBOTH = 8'hAF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_IGNORE
  } link_st_t;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_CMD,
    PH_DATA
  } rx_ph_t;

  typedef struct packed {
    logic valid;
    logic en1;
    logic en0;
  } wr_sel_t;

  function automatic wr_sel_t decode_cmd(input logic [BYTE_W-1:0] code);
    wr_sel_t s;
    s = '0;
    case (code)
      CMD_LOAD0:    s = '{valid: 1'b1, en1: 1'b0, en0: 1'b1};
      CMD_LOAD1:    s = '{valid: 1'b1, en1: 1'b1, en0: 1'b0};
      CMD_LOADBOTH: s = '{valid: 1'b1, en1: 1'b1, en0: 1'b1};
      default:      s = '0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/dws_sync.sv
module dws_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda,
  output logic start_det,
  output logic stop_det
);
  localparam int LINES = 2;
  localparam int PW    = STAGES + 1;

  logic [LINES-1:0]        raw;
  logic [PW-1:0]           pipe [LINES];
  logic [LINES-1:0]        cur;
  logic [LINES-1:0]        prv;

  assign raw = {sda_in, scl_in};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) pipe[g] <= '1;
      else     pipe[g] <= {pipe[g][PW-2:0], raw[g]};
    end
    assign cur[g] = pipe[g][STAGES-1];
    assign prv[g] = pipe[g][STAGES];
  end

  assign sda       = cur[1];
  assign scl_rise  = cur[0] & ~prv[0];
  assign scl_fall  = ~cur[0] & prv[0];
  assign start_det = cur[0] & prv[0] & prv[1] & ~cur[1];
  assign stop_det  = cur[0] & prv[0] & ~prv[1] & cur[1];

endmodule

// File: rtl/dws_regs.sv
module dws_regs #(
  parameter int W = 8,
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] wq [N]
);
  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (rst)           wq[i] <= '0;
      else if (wr_en[i]) wq[i] <= wr_data;
    end
  end
endmodule

// File: rtl/dws_link.sv
module dws_link
  import dws_pkg::*;
#(
  parameter int                  STRAP_W = 3,
  parameter logic [6-STRAP_W:0]  ADDR_HI = 4'b0101
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               sda,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic [STRAP_W-1:0] strap,
  input  logic [BYTE_W-1:0]  rd0,
  input  logic [BYTE_W-1:0]  rd1,
  output logic               sda_pull,
  output logic [1:0]         wr_en,
  output logic [BYTE_W-1:0]  wr_data
);
  localparam logic [CNT_W-1:0] LAST_RX = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_TX = CNT_W'(BYTE_W - 1);

  link_st_t          st;
  rx_ph_t            ph;
  logic [BYTE_W-1:0] sh;
  logic [BYTE_W-1:0] tx;
  logic [CNT_W-1:0]  cnt;
  logic              second;
  logic              mack;
  wr_sel_t           sel;
  logic              byte_ok;

  always_comb begin
    case (ph)
      PH_ADDR: byte_ok = (sh[BYTE_W-1:1] == {ADDR_HI, strap});
      PH_CMD:  byte_ok = decode_cmd(sh).valid;
      PH_DATA: byte_ok = 1'b1;
      default: byte_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    wr_en <= '0;
    if (rst) begin
      st       <= ST_IDLE;
      ph       <= PH_ADDR;
      sh       <= '0;
      tx       <= '0;
      cnt      <= '0;
      second   <= 1'b0;
      mack     <= 1'b0;
      sel      <= '0;
      sda_pull <= 1'b0;
      wr_data  <= '0;
    end else if (stop_det) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      sda_pull <= 1'b0;
    end else if (start_det) begin
      st       <= ST_RX;
      ph       <= PH_ADDR;
      cnt      <= '0;
      sda_pull <= 1'b0;
    end else begin
      case (st)
        ST_RX: begin
          if (scl_rise) begin
            sh  <= {sh[BYTE_W-2:0], sda};
            cnt <= cnt + 1'b1;
          end else if (scl_fall && cnt == LAST_RX) begin
            cnt <= '0;
            if (byte_ok) begin
              sda_pull <= 1'b1;
              st       <= ST_ACK;
            end else begin
              st <= ST_IGNORE;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            case (ph)
              PH_ADDR: begin
                if (sh[0]) begin
                  st       <= ST_TX;
                  tx       <= rd0;
                  sda_pull <= ~rd0[BYTE_W-1];
                  second   <= 1'b0;
                end else begin
                  st       <= ST_RX;
                  ph       <= PH_CMD;
                  sda_pull <= 1'b0;
                end
              end
              PH_CMD: begin
                sel      <= decode_cmd(sh);
                ph       <= PH_DATA;
                st       <= ST_RX;
                sda_pull <= 1'b0;
              end
              default: begin
                wr_en    <= {sel.en1, sel.en0};
                wr_data  <= sh;
                st       <= ST_IGNORE;
                sda_pull <= 1'b0;
              end
            endcase
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt == LAST_TX) begin
              cnt      <= '0;
              sda_pull <= 1'b0;
              st       <= ST_MACK;
            end else begin
              cnt      <= cnt + 1'b1;
              tx       <= {tx[BYTE_W-2:0], 1'b0};
              sda_pull <= ~tx[BYTE_W-2];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack <= ~sda;
          end else if (scl_fall) begin
            if (mack && !second) begin
              second   <= 1'b1;
              tx       <= rd1;
              sda_pull <= ~rd1[BYTE_W-1];
              cnt      <= '0;
              st       <= ST_TX;
            end else begin
              st <= ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/dual_wiper_slave.sv
module dual_wiper_slave
  import dws_pkg::*;
#(
  parameter int                 STRAP_W     = 3,
  parameter logic [6-STRAP_W:0] ADDR_HI     = 4'b0101,
  parameter int                 SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_in,
  input  logic               sda_in,
  input  logic [STRAP_W-1:0] strap,
  output logic [BYTE_W-1:0]  wiper0,
  output logic [BYTE_W-1:0]  wiper1,
  output logic               sda_pull
);
  localparam int NWIPER = 2;

  logic              scl_rise;
  logic              scl_fall;
  logic              sda_s;
  logic              start_det;
  logic              stop_det;
  logic [1:0]        wr_en;
  logic [BYTE_W-1:0] wr_data;
  logic [BYTE_W-1:0] wq [NWIPER];

  dws_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda       (sda_s),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  dws_link #(.STRAP_W(STRAP_W), .ADDR_HI(ADDR_HI)) u_link (
    .clk       (clk),
    .rst       (rst),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda       (sda_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .strap     (strap),
    .rd0       (wq[0]),
    .rd1       (wq[1]),
    .sda_pull  (sda_pull),
    .wr_en     (wr_en),
    .wr_data   (wr_data)
  );

  dws_regs #(.W(BYTE_W), .N(NWIPER)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .wq      (wq)
  );

  assign wiper0 = wq[0];
  assign wiper1 = wq[1];

endmodule

// File: rtl/dws_checker.sv
module dws_checker (
  input logic       clk,
  input logic       rst,
  input logic       scl_in,
  input logic       sda_pull,
  input logic [7:0] wiper0,
  input logic [7:0] wiper1,
  input logic       stop_det
);
  // R1: reset clears both wipers and releases the data line
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (wiper0 == 8'h00 && wiper1 == 8'h00 && !sda_pull));

  // R7: the pull-down enable only moves while the bus clock is low
  a_r7_pull_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_pull) |-> !scl_in);

  // R5: a wiper only changes after the ACK clock has fallen
  a_r5_commit_scl_low: assert property (@(posedge clk) disable iff (rst)
    (!$stable(wiper0) || !$stable(wiper1)) |-> !scl_in);

  // R9: a STOP leaves the data line released
  a_r9_stop_releases: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_pull);
endmodule

bind dual_wiper_slave dws_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .scl_in   (scl_in),
  .sda_pull (sda_pull),
  .wiper0   (wiper0),
  .wiper1   (wiper1),
  .stop_det (stop_det)
);

// File: tb/dual_wiper_slave_tb.sv
module dual_wiper_slave_tb;
  localparam int Q = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic [2:0] strap = 3'b101;
  logic [7:0] wiper0, wiper1;
  logic       sda_pull;
  logic       sda_line;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] exp_w0 = 8'h00;
  logic [7:0] exp_w1 = 8'h00;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  assign sda_line = m_sda & ~sda_pull;

  dual_wiper_slave u_dut (
    .clk(clk), .rst(rst), .scl_in(m_scl), .sda_in(sda_line), .strap(strap),
    .wiper0(wiper0), .wiper1(wiper1), .sda_pull(sda_pull)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic addr_ok(input logic [7:0] a, input logic [2:0] s);
    return a[7:1] == {4'b0101, s};
  endfunction

  function automatic logic cmd_ok(input logic [7:0] c);
    return c == 8'hA9 || c == 8'hAA || c == 8'hAF;
  endfunction

  task automatic bus_start;
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(2 * Q);
  endtask

  task automatic bit_xfer(input logic b, output logic r, output logic stab);
    logic r0;
    m_sda = b; tick(Q);
    m_scl = 1'b1; tick(Q);
    r0 = sda_line; tick(Q);
    r = sda_line;
    stab = (r0 == r);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    logic r, s;
    for (int i = 7; i > 7 - n; i--) bit_xfer(v[i], r, s);
  endtask

  task automatic wr_byte(input logic [7:0] v, output logic ack);
    logic r, s;
    send_bits(v, 8);
    bit_xfer(1'b1, r, s);
    ack = ~r;
  endtask

  task automatic rd_byte(input logic give_ack, output logic [7:0] d, output logic stab);
    logic r, s;
    stab = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(1'b1, r, s);
      d[i] = r;
      stab &= s;
    end
    bit_xfer(~give_ack, r, s);
  endtask

  task automatic wr_txn(input logic [7:0] a, input logic [7:0] c, input logic [7:0] d);
    logic ak, ck, dk, ea, ec;
    string rq;
    rq = (c == 8'hA9) ? "R3" : "R4";
    ea = addr_ok(a, strap) && !a[0];
    ec = ea && cmd_ok(c);
    bus_start;
    wr_byte(a, ak); check("R2 addr ack", ak, ea);
    wr_byte(c, ck); check("R6 cmd ack", ck, ec);
    wr_byte(d, dk); check("R6 data ack", dk, ec);
    bus_stop;
    if (ec) begin
      if (c != 8'hAA) exp_w0 = d;
      if (c != 8'hA9) exp_w1 = d;
    end
    check(rq, wiper0, exp_w0);
    check(rq, wiper1, exp_w1);
  endtask

  task automatic rd_txn(input logic [7:0] a);
    logic ak, ea, s0, s1;
    logic [7:0] d0, d1;
    ea = addr_ok(a, strap) && a[0];
    bus_start;
    wr_byte(a, ak); check("R2 read addr ack", ak, ea);
    rd_byte(1'b1, d0, s0);
    rd_byte(1'b0, d1, s1);
    bus_stop;
    check("R7 first byte", d0, ea ? exp_w0 : 8'hFF);
    check("R7 second byte", d1, ea ? exp_w1 : 8'hFF);
    check("R7 stable while SCL high", {s0, s1}, 2'b11);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic ak, r, s;
    logic [7:0] d0, d1;
    void'($urandom(32'd20240611));
    tick(4);
    check("R1 wiper0 in reset", wiper0, 8'h00);
    check("R1 pull in reset", sda_pull, 1'b0);
    rst = 1'b0;
    tick(1);
    check("R1 wiper0 after reset", wiper0, 8'h00);
    check("R1 wiper1 after reset", wiper1, 8'h00);
    tick(3 * Q);

    // R3 / R4 directed loads
    wr_txn(8'h5A, 8'hA9, 8'h5C);
    wr_txn(8'h5A, 8'hAA, 8'h11);
    wr_txn(8'h5A, 8'hAF, 8'hFF);
    wr_txn(8'h5A, 8'hAF, 8'h00);
    wr_txn(8'h5A, 8'hA9, 8'hC3);
    // R2 wrong strap, then new strap
    wr_txn(8'h54, 8'hAA, 8'h77);
    strap = 3'b010;
    wr_txn(8'h5A, 8'hAA, 8'h77);
    wr_txn(8'h54, 8'hAA, 8'h78);
    // R6 unknown command
    wr_txn(8'h54, 8'hAB, 8'h99);
    wr_txn(8'h54, 8'h00, 8'h99);
    rd_txn(8'h55);

    // R5: value held through the ACK high phase, applied after the fall
    bus_start;
    wr_byte(8'h54, ak);
    wr_byte(8'hA9, ak);
    send_bits(8'h3E, 8);
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    check("R5 ack of data", sda_line, 1'b0);
    check("R5 old value during ACK high", wiper0, exp_w0);
    m_scl = 1'b0; tick(Q);
    exp_w0 = 8'h3E;
    check("R5 new value after ACK fall", wiper0, exp_w0);
    // R10 extra data byte
    wr_byte(8'h81, ak);
    check("R10 extra byte ack", ak, 1'b0);
    bus_stop;
    check("R10 wiper0 unchanged", wiper0, exp_w0);
    check("R10 wiper1 unchanged", wiper1, exp_w1);

    // R9 STOP within a data byte
    bus_start;
    wr_byte(8'h54, ak);
    wr_byte(8'hAF, ak);
    send_bits(8'hE7, 4);
    bus_stop;
    check("R9 partial byte wiper0", wiper0, exp_w0);
    check("R9 partial byte wiper1", wiper1, exp_w1);
    // R9 repeated START within the command byte
    bus_start;
    wr_byte(8'h54, ak);
    send_bits(8'hAA, 3);
    wr_txn(8'h54, 8'hAA, 8'h3C);

    // R8 master NACK after first byte
    bus_start;
    wr_byte(8'h55, ak);
    rd_byte(1'b0, d0, s);
    rd_byte(1'b0, d1, s);
    bus_stop;
    check("R8 first byte", d0, exp_w0);
    check("R8 released after NACK", d1, 8'hFF);

    // random mix
    for (int it = 0; it < 40; it++) begin
      logic [7:0] a, c, d;
      int sel;
      strap = 3'($urandom);
      a = ($urandom % 5 != 0) ? {4'b0101, strap, 1'b0} : 8'($urandom);
      sel = int'($urandom % 5);
      case (sel)
        0: c = 8'hA9;
        1: c = 8'hAA;
        2: c = 8'hAF;
        3: c = 8'($urandom);
        default: c = 8'hA9;
      endcase
      d = 8'($urandom);
      if ($urandom % 4 == 0) rd_txn({a[7:1], 1'b1});
      else                   wr_txn(a, c, d);
    end
    rd_txn({4'b0101, strap, 1'b1});

    r = 1'b0;
    check("R1 line idle at end", sda_pull, r);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule